// File: doc/BRIEF.md
# I2C Target for Reading 16-bit Registers

This block is an I2C target that gives a bus controller read access to a bank of 16-bit registers. The clock line enters as an input. The data line is split into the sensed level (`sda_in`) and an active-high pull-down enable (`sda_oe`), for use with an open-drain pad. The 7-bit target address is `0011 01s`, where `s` is the `addr_sel` pin, so two copies can share one bus.

A transaction first loads a register pointer. The controller addresses the block with R/W=0 and sends one pointer byte. After a repeated START, the controller addresses the block again, this time with R/W=1. The block then returns registers as byte pairs, high byte first. It moves the pointer on after each pair that the controller acknowledges in full.

The register bank sits behind a plain parallel port. The block presents the pointer on `rd_addr` and takes the word from `rd_data`. It latches the whole word at the start of each pair.

Top module: `i2c_reg16_reader`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 0011 01s, with s taken from `addr_sel`. For any other address it leaves SDA released through the acknowledge bit, and it ignores the bus until the next START.
- R2: In a write-direction transfer (bit 0 of the address byte is 0), the block acknowledges the matching address byte and then the pointer byte that follows it.
- R3: The pointer becomes the low seven bits of the pointer byte. A byte whose top bit is 1 is still acknowledged, and that bit is discarded (0x85 selects register 5).
- R4: After a repeated START, the block acknowledges its address with bit 0 equal to 1 (read).
- R5: In a read, each register goes out as two bytes: bits 15..8 first, then bits 7..0. Within each byte the most significant bit goes first.
- R6: When the controller acknowledges a low byte, the pointer increases by one and the next register's pair follows. After register 127 comes register 0.
- R7: A NACK from the controller ends the read. SDA is released, and the pointer does not advance for the pair that was NACKed.
- R8: SDA changes only while SCL is low. Its level holds through each SCL high phase.
- R9: Both bytes of a pair come from one sample of `rd_data`, taken when the pair starts. A change of the bank between the two bytes has no effect on the low byte.
- R10: After reset, after a STOP, and after a START carrying another target's address, the block is idle with SDA released. The pointer keeps its value, so a later read that has no pointer phase resumes at that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Sensed bus data level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 1 | Sets bit 0 of the 7-bit target address |
| rd_addr | output | 7 | Register pointer to the bank |
| rd_data | input | 16 | Register word returned by the bank |

## Verification
The bench sweeps every 7-bit address for both settings of the select pin. A design with a wrong or inverted select bit would answer for its neighbour or for nobody. It then reads all 128 registers in one burst and runs past 127. That catches a pointer that stalls, skips, wraps early, or advances after each byte instead of each pair. It also changes the bank between the high and low bytes, which exposes a design that fetches each byte on its own. It checks that a NACKed pair, a STOP, or a foreign START leaves the pointer where it was. Each received bit is sampled twice within its SCL high phase, so a design that updates SDA while SCL is high shows up as an unstable bit.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,   // ignoring the bus until a START
      ST_ADDR,   // shifting in the address byte
      ST_AACK,   // driving ACK for our address
      ST_REG,    // shifting in the pointer byte
      ST_RACK,   // driving ACK for the pointer byte
      ST_TX,     // shifting out a data byte
      ST_TACK    // listening to the controller's ACK/NACK
   } rr_state_t;
endpackage

// File: rtl/i2c_rr_sync.sv
module i2c_rr_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_rr_sync needs at least two stages");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;               // idle bus level is high
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_rr_cond.sv
module i2c_rr_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_reg16_reader.sv
module i2c_reg16_reader #(
   parameter logic [5:0] DEV_HI      = 6'b001101,
   parameter int         PTR_W       = 7,
   parameter int         DATA_W      = 16,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   input  logic              addr_sel,
   output logic [PTR_W-1:0]  rd_addr,
   input  logic [DATA_W-1:0] rd_data
);
   import i2c_rr_pkg::*;

   localparam int NBYTES = DATA_W / 8;
   localparam int BI_W   = (NBYTES > 2) ? $clog2(NBYTES) : 1;
   localparam logic [BI_W-1:0] LAST_BYTE = BI_W'(NBYTES - 1);

   if (PTR_W < 1 || PTR_W > 7) begin : g_bad_ptr
      $error("PTR_W must fit the seven low bits of the pointer byte");
   end
   if (DATA_W % 8 != 0 || NBYTES < 2) begin : g_bad_data
      $error("DATA_W must be a multiple of 8 and at least 16");
   end

   logic [1:0] raw_bus, syn_bus;
   logic       scl_s, sda_s;
   logic       scl_rise, scl_fall, start_det, stop_det;

   assign raw_bus = {scl_in, sda_in};
   assign scl_s   = syn_bus[1];
   assign sda_s   = syn_bus[0];

   i2c_rr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(syn_bus)
   );

   i2c_rr_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   rr_state_t         state;
   logic [3:0]        bit_cnt;
   logic [7:0]        rx_sr;
   logic [7:0]        tx_sr;
   logic              rw_q;
   logic              ack_q;
   logic [PTR_W-1:0]  ptr;
   logic [DATA_W-1:0] word_q;
   logic [BI_W-1:0]   byte_idx;
   logic              addr_hit;
   logic              load_en;

   function automatic logic [7:0] pick(input logic [DATA_W-1:0] w,
                                       input logic [BI_W-1:0]   i);
      logic [DATA_W-1:0] sh;
      sh = w >> (8 * (NBYTES - 1 - int'(i)));
      return sh[7:0];
   endfunction

   assign addr_hit = (rx_sr[7:1] == {DEV_HI, addr_sel});
   assign load_en  = (state == ST_REG) && scl_fall && (bit_cnt == 4'd8)
                     && !start_det && !stop_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         rw_q     <= 1'b0;
         ack_q    <= 1'b0;
         ptr      <= '0;
         word_q   <= '0;
         byte_idx <= '0;
      end else if (start_det) begin
         state   <= ST_ADDR;
         bit_cnt <= '0;
      end else if (stop_det) begin
         state <= ST_IDLE;
      end else begin
         case (state)
            ST_ADDR, ST_REG: begin
               if (scl_rise && bit_cnt < 4'd8) begin
                  rx_sr   <= {rx_sr[6:0], sda_s};
                  bit_cnt <= bit_cnt + 4'd1;
               end
               if (scl_fall && bit_cnt == 4'd8) begin
                  if (state == ST_ADDR) begin
                     rw_q  <= rx_sr[0];
                     state <= addr_hit ? ST_AACK : ST_IDLE;
                  end else begin
                     ptr   <= rx_sr[PTR_W-1:0];
                     state <= ST_RACK;
                  end
               end
            end
            ST_AACK: if (scl_fall) begin
               bit_cnt <= '0;
               if (rw_q) begin
                  word_q   <= rd_data;
                  tx_sr    <= pick(rd_data, '0);
                  byte_idx <= '0;
                  state    <= ST_TX;
               end else begin
                  state <= ST_REG;
               end
            end
            ST_RACK: if (scl_fall) state <= ST_IDLE;
            ST_TX: if (scl_fall) begin
               if (bit_cnt == 4'd7) begin
                  state <= ST_TACK;
               end else begin
                  tx_sr   <= {tx_sr[6:0], 1'b0};
                  bit_cnt <= bit_cnt + 4'd1;
               end
            end
            ST_TACK: begin
               if (scl_rise) begin
                  ack_q <= !sda_s;
                  if (!sda_s && byte_idx == LAST_BYTE) ptr <= ptr + PTR_W'(1);
               end
               if (scl_fall) begin
                  bit_cnt <= '0;
                  if (!ack_q) begin
                     state <= ST_IDLE;
                  end else if (byte_idx == LAST_BYTE) begin
                     word_q   <= rd_data;
                     tx_sr    <= pick(rd_data, '0);
                     byte_idx <= '0;
                     state    <= ST_TX;
                  end else begin
                     tx_sr    <= pick(word_q, byte_idx + BI_W'(1));
                     byte_idx <= byte_idx + BI_W'(1);
                     state    <= ST_TX;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (state)
         ST_AACK, ST_RACK: sda_oe = 1'b1;
         ST_TX:            sda_oe = ~tx_sr[7];
         default:          sda_oe = 1'b0;
      endcase
   end

   assign rd_addr = ptr;
endmodule

// File: rtl/i2c_rr_chk.sv
module i2c_rr_chk #(
   parameter logic [5:0] DEV_HI = 6'b001101,
   parameter int         PTR_W  = 7
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_s,
   input logic                  sda_oe,
   input logic                  start_det,
   input logic                  stop_det,
   input logic                  scl_fall,
   input logic                  load_en,
   input logic                  ack_q,
   input logic                  rw_q,
   input logic                  addr_sel,
   input logic [7:0]            rx_sr,
   input logic [PTR_W-1:0]      ptr,
   input i2c_rr_pkg::rr_state_t state
);
   import i2c_rr_pkg::*;

   // R1: our ACK phase is only entered for a matching address
   p_ack_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_AACK) |-> (rx_sr[7:1] == {DEV_HI, addr_sel}));

   // R5: data is only shifted out in a read-direction transfer
   p_tx_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX) |-> rw_q);

   // R6: the pointer moves only by a load or by a single step
   p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr != $past(ptr)) |-> ($past(load_en) || ptr == $past(ptr) + PTR_W'(1)));

   // R7: after a NACK from the controller, SDA is released
   p_nack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(state == ST_TACK && scl_fall && !ack_q && !start_det && !stop_det)
      |-> !sda_oe);

   // R8: SDA drive is steady while SCL stays high
   p_sda_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det))
      |-> $stable(sda_oe));

   // R10: a STOP leaves the line released
   p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop_det) |-> !sda_oe);
endmodule

bind i2c_reg16_reader i2c_rr_chk #(.DEV_HI(DEV_HI), .PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
   .start_det(start_det), .stop_det(stop_det), .scl_fall(scl_fall),
   .load_en(load_en), .ack_q(ack_q), .rw_q(rw_q), .addr_sel(addr_sel),
   .rx_sr(rx_sr), .ptr(ptr), .state(state)
);

// File: tb/sim_i2c_reg16_reader.sv
module sim_i2c_reg16_reader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        m_low = 1'b0;
   logic        addr_sel = 1'b0;
   logic        sda_oe;
   logic [6:0]  rd_addr;
   logic [15:0] rd_data;
   logic        sda_line;
   int          epoch = 0;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   function automatic logic [15:0] model(input logic [6:0] a, input int ep);
      return 16'(int'(a) * 517 + 32'h1234 + ep * 3855);
   endfunction

   assign sda_line = !(m_low || sda_oe);
   assign rd_data  = model(rd_addr, epoch);

   i2c_reg16_reader u0 (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
      .sda_oe(sda_oe), .addr_sel(addr_sel), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      m_low = 1'b0; wt(3); scl = 1'b1; wt(8); m_low = 1'b1; wt(8); scl = 1'b0; wt(1);
   endtask

   task automatic bus_stop;
      wt(3); m_low = 1'b1; wt(5); scl = 1'b1; wt(8); m_low = 1'b0; wt(8);
   endtask

   task automatic send_bit(input bit b);
      wt(3); m_low = !b; wt(5); scl = 1'b1; wt(8); scl = 1'b0;
   endtask

   task automatic recv_bit(output bit v, output bit stab);
      wt(3); m_low = 1'b0; wt(5); scl = 1'b1; wt(4); v = sda_line;
      wt(3); stab = (sda_line == v); wt(1); scl = 1'b0;
   endtask

   task automatic write_byte(input logic [7:0] b, output bit ack);
      bit v, s;
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      recv_bit(v, s);
      ack = !v;
   endtask

   task automatic read_byte(input bit give_ack, output logic [7:0] d, output bit stab);
      bit v, s;
      stab = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(v, s);
         d[i] = v;
         stab &= s;
      end
      send_bit(!give_ack);
   endtask

   task automatic set_ptr(input logic [7:0] b);
      bit ack;
      bus_start;
      write_byte({6'b001101, addr_sel, 1'b0}, ack);
      chk(ack, "R2 write address ack", ack, 1);
      write_byte(b, ack);
      chk(ack, "R2 pointer byte ack", ack, 1);
   endtask

   // repeated START, read address, then n pairs from pointer p, NACK on the last
   task automatic read_pairs(input int n, input logic [6:0] p0);
      bit ack, stab;
      logic [7:0] hi, lo;
      logic [6:0] p;
      logic [15:0] e;
      p = p0;
      bus_start;
      write_byte({6'b001101, addr_sel, 1'b1}, ack);
      chk(ack, "R4 read address ack", ack, 1);
      for (int k = 0; k < n; k++) begin
         e = model(p, epoch);
         read_byte(1'b1, hi, stab);
         chk(stab, "R8 high byte stable", 0, 1);
         read_byte(k < n - 1, lo, stab);
         chk(stab, "R8 low byte stable", 0, 1);
         if (k > 0 && p == 7'd0)
            chk({hi, lo} == e, "R6 wrap 127 to 0", {hi, lo}, e);
         else
            chk({hi, lo} == e, "R5 R6 pair", {hi, lo}, e);
         p = p + 7'd1;
      end
      wt(6);
      chk(sda_oe == 1'b0, "R7 release after NACK", sda_oe, 0);
      bus_stop;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit ack, stab;
      logic [7:0] hi, lo;
      wt(5);
      rst_n = 1'b1;
      wt(5);
      chk(sda_oe == 1'b0, "R10 reset release", sda_oe, 0);
      chk(rd_addr == 7'd0, "R10 reset pointer", rd_addr, 0);

      // R1: all addresses, both select settings
      for (int sel = 0; sel < 2; sel++) begin
         addr_sel = sel[0];
         wt(4);
         for (int a = 0; a < 128; a++) begin
            bus_start;
            write_byte({a[6:0], 1'b0}, ack);
            chk(ack == (a == (26 + sel)), "R1 address match", ack, a == (26 + sel));
            bus_stop;
         end
      end

      // R2 R4 R5 R6: burst over the whole bank and past the wrap
      addr_sel = 1'b1;
      wt(4);
      set_ptr(8'h00);
      read_pairs(130, 7'd0);

      // R3: top bit of the pointer byte is dropped
      set_ptr(8'h85);
      read_pairs(1, 7'd5);
      chk(rd_addr == 7'd5, "R3 pointer masked", rd_addr, 5);

      // R9: bank changes between the two bytes of a pair
      set_ptr(8'h14);
      bus_start;
      write_byte({6'b001101, addr_sel, 1'b1}, ack);
      chk(ack, "R4 read address ack", ack, 1);
      read_byte(1'b1, hi, stab);
      epoch = 1;
      read_byte(1'b1, lo, stab);
      chk({hi, lo} == model(7'd20, 0), "R9 pair from one sample", {hi, lo}, model(7'd20, 0));
      read_byte(1'b1, hi, stab);
      read_byte(1'b0, lo, stab);
      chk({hi, lo} == model(7'd21, 1), "R9 next pair new sample", {hi, lo}, model(7'd21, 1));
      bus_stop;

      // R7: NACKed pair does not advance the pointer; read without pointer phase
      chk(rd_addr == 7'd21, "R7 pointer held on NACK", rd_addr, 21);
      read_pairs(1, 7'd21);

      // R10: STOP mid-transfer and a foreign START keep the pointer
      set_ptr(8'h28);
      bus_stop;
      bus_start;
      write_byte(8'h20, ack);
      chk(!ack, "R10 foreign address not acked", ack, 0);
      write_byte(8'h00, ack);
      chk(!ack && sda_oe == 1'b0, "R10 idle after foreign START", ack, 0);
      bus_stop;
      bus_start;
      write_byte({6'b001101, addr_sel, 1'b0}, ack);
      chk(ack, "R2 write address ack", ack, 1);
      bus_stop;
      chk(sda_oe == 1'b0, "R10 release after STOP", sda_oe, 0);
      chk(rd_addr == 7'd40, "R10 pointer kept", rd_addr, 40);
      read_pairs(2, 7'd40);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule